// File: doc/BRIEF.md
# Conversion Result Read-Out Bank

This block holds the latest conversion results of six converter channels. It presents them as 16-bit tagged words on a parallel read port. Results arrive in pairs from a conversion scheduler. A pair code names the channel pair (A, B or C), and each strobe carries the member-0 and member-1 results together. A host reads the bank with an active-low chip select and an active-low read strobe. A 3-bit address/mode input sets how each read picks its word.

There are three read disciplines. A direct address reads one channel's register. Cycle mode steps through all six channels in a fixed order. FIFO mode returns results in the order they were converted, across three stored pairs. Byte mode splits each word into two 8-bit reads. Any write that arrives while the read strobe is low is held back until the strobe is released. The block drives no pads: it gives a data bus plus an output-enable flag that an outer level can turn into tristate control. Inputs are taken as synchronous to `clk`, and reset is synchronous and active high.

Top module: `rbank_top`

## Requirements
- R1: Every read word is laid out as valid flag in bit 15, channel code in bits 14:12, and the 12-bit two's-complement result in bits 11:0 (MSB at bit 11).
- R2: Channel codes are A0=000, A1=001, B0=010, B1=011, C0=100, C1=101. On the write strobe, pair code 0/1/2 selects pair A/B/C and member 0 or 1 takes the first or second result. Pair code 3 stores nothing.
- R3: Address values 000 to 101 return that channel's stored word, and reading does not consume it.
- R4: The address/mode input is used only while chip select and read are both low. The output enable is high only then, and the data bus is all zero whenever the output enable is low.
- R5: With address 110, each completed read returns the next channel in the order A0, A1, B0, B1, C0, C1, then A0 again. After reset the first such read returns A0.
- R6: Once a read with address 111 has completed, later pairs are queued. With address 111, reads return the queued words oldest first, member 0 before member 1, and each completed read removes the head word.
- R7: Reset clears every stored word, empties the queue, sets the internal mode to 000 and sets the cycle position to A0. A read from an empty register or an empty queue returns a word with valid flag 0.
- R8: A pair written while the read strobe is low is not visible until the strobe has returned high. If the release coincides with a queue read, the head is removed first and the new pair is appended behind the remaining words.
- R9: With byte mode high, a read returns bits 7:0 of the selected word in bits 7:0, and the next read returns bits 15:8 of the same word. The upper 8 output bits are zero. Cycle and queue positions advance only after the upper half has been read.
- R10: A pair that finds no room for two more words in the 6-word queue is dropped, and the overflow flag is high for one cycle.
- R11: A read strobe pulse with chip select high returns nothing and does not advance the cycle or queue position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Result-pair write strobe |
| wr_pair | input | 2 | Pair code: 0=A, 1=B, 2=C |
| wr_d0 | input | 12 | Member-0 result |
| wr_d1 | input | 12 | Member-1 result |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low; a read completes on its rising edge |
| addr | input | 3 | Channel address or mode (110 cycle, 111 queue) |
| byte_mode | input | 1 | Deliver words as two 8-bit halves |
| dout | output | 16 | Read data |
| dout_oe | output | 1 | Read data enable for the outer pad level |
| ovf | output | 1 | One-cycle pulse when a pair is dropped by a full queue |

## Verification
A write strobe can arrive during a held queue read. The deferred pair is then committed on the same clock edge that finishes that read and pops the queue head. The bench provokes this by holding a queue read on a two-word queue and writing a new pair during the hold. It checks that the head is unchanged while the strobe is low. It then releases the strobe and expects the surviving member-1 word, then the new pair's two words, then an empty word. A wrong offset in that shared edge would either overwrite the survivor or leave a gap with a cleared valid flag.

// File: rtl/rbank_pkg.sv
package rbank_pkg;
    localparam int DW     = 12;            // result width
    localparam int CW     = 3;             // channel code width
    localparam int WW     = 1 + CW + DW;   // read word width
    localparam int BW     = 8;             // byte-mode half width
    localparam int NCH    = 6;             // channels
    localparam int NPAIR  = NCH / 2;       // channel pairs
    localparam int PW     = 2;             // pair code width

    localparam logic [2:0] MD_CYCLE = 3'b110;
    localparam logic [2:0] MD_FIFO  = 3'b111;

    typedef struct packed {
        logic          vld;
        logic [CW-1:0] ch;
        logic [DW-1:0] dat;
    } word_t;

    typedef struct packed {
        logic [PW-1:0] pair;
        logic [DW-1:0] d0;
        logic [DW-1:0] d1;
    } pair_t;

    function automatic word_t mk_word(logic [PW-1:0] pair, logic member, logic [DW-1:0] d);
        word_t w;
        w.vld = 1'b1;
        w.ch  = {pair, member};
        w.dat = d;
        return w;
    endfunction
endpackage

// File: rtl/rbank_strobe.sv
module rbank_strobe
    import rbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic [2:0] addr,
    input  logic       byte_mode,
    output logic [2:0] mode_q,
    output logic       hi_phase,
    output logic       adv
);
    logic rd_q;
    logic cs_seen;
    logic rise;
    logic done;

    assign rise = rd_n && !rd_q;
    assign done = rise && cs_seen;
    assign adv  = done && (!byte_mode || hi_phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q     <= 1'b1;
            cs_seen  <= 1'b0;
            mode_q   <= 3'b000;
            hi_phase <= 1'b0;
        end else begin
            rd_q <= rd_n;
            if (!rd_n && !cs_n) begin
                cs_seen <= 1'b1;
                mode_q  <= addr;
            end else if (rise) begin
                cs_seen <= 1'b0;
            end
            if (!byte_mode)
                hi_phase <= 1'b0;
            else if (done)
                hi_phase <= !hi_phase;
        end
    end
endmodule

// File: rtl/rbank_defer.sv
module rbank_defer
    import rbank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_n,
    input  logic  wr_ok,
    input  pair_t wr_in,
    output logic  commit,
    output pair_t cm_pair
);
    logic  pend_v;
    pair_t pend;

    assign commit  = rd_n && (pend_v || wr_ok);
    assign cm_pair = pend_v ? pend : wr_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend   <= '0;
        end else if (!rd_n) begin
            if (wr_ok) begin
                pend   <= wr_in;
                pend_v <= 1'b1;
            end
        end else if (pend_v && wr_ok) begin
            pend <= wr_in;
        end else begin
            pend_v <= 1'b0;
        end
    end
endmodule

// File: rtl/rbank_chregs.sv
module rbank_chregs
    import rbank_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  pair_t               wp,
    output word_t [NCH-1:0]     regs
);
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        for (genvar m = 0; m < 2; m++) begin : g_mem
            always_ff @(posedge clk) begin
                if (rst)
                    regs[2*p+m] <= '0;
                else if (we && wp.pair == PW'(p))
                    regs[2*p+m] <= mk_word(wp.pair, 1'(m), (m == 0) ? wp.d0 : wp.d1);
            end
        end
    end
endmodule

// File: rtl/rbank_fifo.sv
module rbank_fifo
    import rbank_pkg::*;
#(
    parameter int FDEPTH = 6,
    localparam int CNTW  = $clog2(FDEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  pair_t           wp,
    input  logic            pop,
    output word_t           head,
    output logic [CNTW-1:0] cnt,
    output logic            ovf
);
    word_t ent [FDEPTH];
    word_t sh  [FDEPTH];
    word_t nxt [FDEPTH];
    logic [CNTW-1:0] n;
    logic fits;
    logic push_ok;
    word_t w0, w1;

    assign n       = (pop && cnt != '0) ? cnt - 1'b1 : cnt;
    assign fits    = (n <= CNTW'(FDEPTH - 2));
    assign push_ok = push && fits;
    assign w0      = mk_word(wp.pair, 1'b0, wp.d0);
    assign w1      = mk_word(wp.pair, 1'b1, wp.d1);
    assign head    = ent[0];

    for (genvar i = 0; i < FDEPTH; i++) begin : g_ent
        if (i == FDEPTH - 1) begin : g_top
            assign sh[i] = pop ? '0 : ent[i];
        end else begin : g_mid
            assign sh[i] = pop ? ent[i+1] : ent[i];
        end
        assign nxt[i] = (push_ok && n == CNTW'(i))          ? w0 :
                        (push_ok && n + 1'b1 == CNTW'(i))   ? w1 : sh[i];
        always_ff @(posedge clk) begin
            if (rst) ent[i] <= '0;
            else     ent[i] <= nxt[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            cnt <= push_ok ? n + CNTW'(2) : n;
            ovf <= push && !fits;
        end
    end
endmodule

// File: rtl/rbank_top.sv
module rbank_top
    import rbank_pkg::*;
#(
    parameter int FDEPTH = 6,
    localparam int CNTW  = $clog2(FDEPTH + 1),
    localparam int PTRW  = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_pair,
    input  logic [DW-1:0] wr_d0,
    input  logic [DW-1:0] wr_d1,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic [2:0]    addr,
    input  logic          byte_mode,
    output logic [WW-1:0] dout,
    output logic          dout_oe,
    output logic          ovf
);
    pair_t            wr_in, cm_pair;
    logic             wr_ok, commit;
    logic [2:0]       mode_q;
    logic             hi_phase, adv;
    logic             in_fifo;
    word_t [NCH-1:0]  regs;
    word_t            fhead, sel;
    logic [CNTW-1:0]  fifo_cnt;
    logic [PTRW-1:0]  cyc_ptr;

    assign wr_in   = '{pair: wr_pair, d0: wr_d0, d1: wr_d1};
    assign wr_ok   = wr_en && (wr_pair < PW'(NPAIR));
    assign in_fifo = (mode_q == MD_FIFO);

    rbank_defer i_defer (
        .clk(clk), .rst(rst), .rd_n(rd_n), .wr_ok(wr_ok), .wr_in(wr_in),
        .commit(commit), .cm_pair(cm_pair)
    );

    rbank_strobe i_strobe (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .addr(addr),
        .byte_mode(byte_mode), .mode_q(mode_q), .hi_phase(hi_phase), .adv(adv)
    );

    rbank_chregs i_chregs (
        .clk(clk), .rst(rst), .we(commit && !in_fifo), .wp(cm_pair), .regs(regs)
    );

    rbank_fifo #(.FDEPTH(FDEPTH)) i_fifo (
        .clk(clk), .rst(rst), .push(commit && in_fifo), .wp(cm_pair),
        .pop(adv && in_fifo), .head(fhead), .cnt(fifo_cnt), .ovf(ovf)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cyc_ptr <= '0;
        else if (adv && mode_q == MD_CYCLE)
            cyc_ptr <= (cyc_ptr == PTRW'(NCH - 1)) ? '0 : cyc_ptr + 1'b1;
    end

    always_comb begin
        case (addr)
            MD_CYCLE: sel = regs[cyc_ptr];
            MD_FIFO:  sel = fhead;
            default:  sel = regs[addr[PTRW-1:0]];
        endcase
    end

    assign dout_oe = !cs_n && !rd_n;

    always_comb begin
        if (!dout_oe)
            dout = '0;
        else if (byte_mode)
            dout = hi_phase ? WW'(sel[WW-1:BW]) : WW'(sel[BW-1:0]);
        else
            dout = sel;
    end
endmodule

// File: rtl/rbank_chk.sv
module rbank_chk
    import rbank_pkg::*;
#(
    parameter int FDEPTH = 6,
    localparam int CNTW  = $clog2(FDEPTH + 1),
    localparam int PTRW  = $clog2(NCH)
) (
    input logic            clk,
    input logic            rst,
    input logic            cs_n,
    input logic            rd_n,
    input logic [WW-1:0]   dout,
    input logic            dout_oe,
    input logic            ovf,
    input logic            commit,
    input logic [2:0]      mode_q,
    input logic [CNTW-1:0] fifo_cnt,
    input logic [PTRW-1:0] cyc_ptr
);
    // R4
    bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !dout_oe |-> dout == '0);
    // R4
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(rd_n) || $past(cs_n))) |-> $stable(mode_q));
    // R8
    defer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> rd_n);
    // R10
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CNTW'(FDEPTH));
    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |-> $past(fifo_cnt) >= CNTW'(FDEPTH - 1));
    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_ptr < PTRW'(NCH));
    // R7
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fifo_cnt == '0 && mode_q == 3'b000 && cyc_ptr == '0 && !ovf));
endmodule

bind rbank_top rbank_chk #(.FDEPTH(FDEPTH)) i_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .dout(dout),
    .dout_oe(dout_oe), .ovf(ovf), .commit(commit), .mode_q(mode_q),
    .fifo_cnt(fifo_cnt), .cyc_ptr(cyc_ptr)
);

// File: tb/test_rbank_top.sv
`timescale 1ns/1ps
module test_rbank_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_pair = '0;
    logic [11:0] wr_d0 = '0, wr_d1 = '0;
    logic        cs_n = 1'b1, rd_n = 1'b1;
    logic [2:0]  addr = '0;
    logic        byte_mode = 1'b0;
    logic [15:0] dout;
    logic        dout_oe, ovf;

    int total = 0;
    int bad   = 0;

    typedef struct { logic [15:0] w; string tag; } exp_t;
    exp_t exp_q[$];
    event smp_ev;

    always #2.5 clk = ~clk;

    rbank_top i_rbank_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_pair(wr_pair), .wr_d0(wr_d0),
        .wr_d1(wr_d1), .cs_n(cs_n), .rd_n(rd_n), .addr(addr),
        .byte_mode(byte_mode), .dout(dout), .dout_oe(dout_oe), .ovf(ovf)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] expv, input string tag);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // monitor: pops the scoreboard as each read result is sampled
    initial begin
        forever begin
            @(smp_ev);
            if (exp_q.size() == 0) begin
                check(16'hdead, 16'hbeef, "scoreboard underflow");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(dout, e.w, e.tag);
                check({15'd0, dout_oe}, 16'd1, {e.tag, " R4 oe"});
            end
        end
    end

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] p, input logic [11:0] a, input logic [11:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_pair = p; wr_d0 = a; wr_d1 = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] expv, input string tag);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        exp_q.push_back('{w: expv, tag: tag});
        @(negedge clk);
        -> smp_ev;
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R7 R4: quiet bus and empty bank after reset
        check(dout, 16'h0000, "R4 idle bus");
        check({15'd0, dout_oe}, 16'd0, "R4 idle oe");
        check({15'd0, ovf}, 16'd0, "R7 ovf after reset");
        rd(3'd0, 16'h0000, "R7 empty A0");

        // R1 R2 R3: direct reads
        wr(2'd0, 12'h123, 12'hABC);
        wr(2'd1, 12'h456, 12'h800);
        wr(2'd2, 12'h7FF, 12'h001);
        rd(3'd0, 16'h8123, "R1 A0");
        rd(3'd1, 16'h9ABC, "R2 A1");
        rd(3'd2, 16'hA456, "R2 B0");
        rd(3'd3, 16'hB800, "R2 B1");
        rd(3'd4, 16'hC7FF, "R2 C0");
        rd(3'd5, 16'hD001, "R2 C1");
        rd(3'd0, 16'h8123, "R3 reread A0");

        // R5: cycle order with wrap
        rd(3'd6, 16'h8123, "R5 cyc A0");
        rd(3'd6, 16'h9ABC, "R5 cyc A1");
        rd(3'd6, 16'hA456, "R5 cyc B0");
        rd(3'd6, 16'hB800, "R5 cyc B1");
        rd(3'd6, 16'hC7FF, "R5 cyc C0");
        rd(3'd6, 16'hD001, "R5 cyc C1");
        rd(3'd6, 16'h8123, "R5 cyc wrap A0");

        // R11: strobe with chip select high
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; addr = 3'd6;
        @(negedge clk);
        check(dout, 16'h0000, "R11 no data with cs high");
        check({15'd0, dout_oe}, 16'd0, "R11 oe with cs high");
        rd_n = 1'b1;
        @(negedge clk);
        rd(3'd6, 16'h9ABC, "R11 cyc not advanced");

        // R9: byte mode in cycle mode
        byte_mode = 1'b1;
        rd(3'd6, 16'h0056, "R9 B0 low");
        rd(3'd6, 16'h00A4, "R9 B0 high");
        rd(3'd6, 16'h0000, "R9 B1 low");
        rd(3'd6, 16'h00B8, "R9 B1 high");
        byte_mode = 1'b0;
        rd(3'd6, 16'hC7FF, "R9 advance after high");

        // R8: deferred write during a held read
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; addr = 3'd0;
        @(negedge clk); wr_en = 1'b1; wr_pair = 2'd0; wr_d0 = 12'h111; wr_d1 = 12'h222;
        @(negedge clk); wr_en = 1'b0;
        check(dout, 16'h8123, "R8 held read unchanged");
        @(negedge clk);
        check(dout, 16'h8123, "R8 held read unchanged later");
        rd_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
        rd(3'd0, 16'h8111, "R8 A0 after release");
        rd(3'd1, 16'h9222, "R8 A1 after release");

        // R2: pair code 3 stores nothing
        wr(2'd3, 12'hFFF, 12'hFFF);
        rd(3'd0, 16'h8111, "R2 pair3 A0");
        rd(3'd5, 16'hD001, "R2 pair3 C1");

        // R6 R7: queue mode after a fresh reset
        do_reset();
        rd(3'd0, 16'h0000, "R7 cleared A0");
        rd(3'd7, 16'h0000, "R6 arming read empty");
        wr(2'd1, 12'h010, 12'h020);
        wr(2'd0, 12'h030, 12'h040);
        rd(3'd7, 16'hA010, "R6 q B0");
        rd(3'd7, 16'hB020, "R6 q B1");
        rd(3'd7, 16'h8030, "R6 q A0");
        rd(3'd7, 16'h9040, "R6 q A1");
        rd(3'd7, 16'h0000, "R7 q empty");

        // R8: pop and deferred push on the same edge
        wr(2'd2, 12'h700, 12'h701);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; addr = 3'd7;
        @(negedge clk); wr_en = 1'b1; wr_pair = 2'd1; wr_d0 = 12'h600; wr_d1 = 12'h601;
        @(negedge clk); wr_en = 1'b0;
        check(dout, 16'hC700, "R8 q head held");
        rd_n = 1'b1; cs_n = 1'b1;
        @(negedge clk);
        rd(3'd7, 16'hD701, "R8 q survivor");
        rd(3'd7, 16'hA600, "R8 q new B0");
        rd(3'd7, 16'hB601, "R8 q new B1");
        rd(3'd7, 16'h0000, "R8 q empty");

        // R10: overflow
        wr(2'd0, 12'h100, 12'h101);
        wr(2'd1, 12'h200, 12'h201);
        wr(2'd2, 12'h300, 12'h301);
        check({15'd0, ovf}, 16'd0, "R10 no ovf at full");
        wr(2'd0, 12'h3AA, 12'h3BB);
        check({15'd0, ovf}, 16'd1, "R10 ovf pulse");
        @(negedge clk);
        check({15'd0, ovf}, 16'd0, "R10 ovf one cycle");
        rd(3'd7, 16'h8100, "R10 q0");
        rd(3'd7, 16'h9101, "R10 q1");
        rd(3'd7, 16'hA200, "R10 q2");
        rd(3'd7, 16'hB201, "R10 q3");
        rd(3'd7, 16'hC300, "R10 q4");
        rd(3'd7, 16'hD301, "R10 q5");
        rd(3'd7, 16'h0000, "R10 dropped pair absent");

        // R9: byte mode in queue mode
        wr(2'd0, 12'h5A5, 12'h0F0);
        byte_mode = 1'b1;
        rd(3'd7, 16'h00A5, "R9 q A0 low");
        rd(3'd7, 16'h0085, "R9 q A0 high");
        rd(3'd7, 16'h00F0, "R9 q A1 low");
        rd(3'd7, 16'h0090, "R9 q A1 high");
        rd(3'd7, 16'h0000, "R9 q empty low");
        byte_mode = 1'b0;

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) check(16'(exp_q.size()), 16'd0, "scoreboard leftover");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule